// File: doc/BRIEF.md
# Full-Duplex Clocked Serial Port

This block moves one byte at a time between a processor and a serial line. The serial output and the serial input are timed by one serial clock. Software loads a transmit holding register, programs a control word and sets a run bit. At each byte boundary the engine copies the holding register into a shifter. It drives one bit per falling serial-clock edge and captures one input bit per rising edge. After eight rising edges it hands the captured byte to a receive holding register and raises a one-cycle interrupt.

The serial clock can come from an internal divider of the system clock (`HALF_DIV` system cycles per half period, idle level high). It can also come from an external pin, which is synchronized and edge-detected inside the block. While the run bit stays set, bytes follow one another without a gap, so software can refill the transmit register during a byte. When a byte finishes while the previous one is still unread, the block flags an overrun. That flag silences the interrupt until software clears it.

Register map (`addr`): 0 control, 1 status, 2 transmit holding, 3 receive holding. Control bits: [1:0] mode, [2] run, [3] external clock select, [4] LSB-first. Status bits: [0] transfer active, [1] shift window, [2] transmit holding empty, [3] receive full, [4] overrun.

Top module: `sync_serial_xcvr`

## Requirements
- R1: A transfer starts only when control mode bits [1:0] equal binary 10. With any other mode, setting the run bit leaves status bit 0 at 0 and the serial clock output high.
- R2: A write to the transmit holding register (addr 2) clears status bit 2 to 0 on the next cycle.
- R3: Status bit 0 rises in the system cycle that follows a serial-clock falling edge after the run bit is set, and never before that edge.
- R4: Output bits change on falling serial-clock edges and input bits are sampled on rising edges. Control bit 4 set sends and receives bit 0 first; clear sends and receives bit 7 first.
- R5: Status bit 1 is set at the first falling edge of a byte and cleared at the eighth falling edge. It is only ever high while status bit 0 is high.
- R6: Status bit 2 returns to 1 at the first rising edge after the holding register was copied into the shifter, unless software writes it again in that cycle.
- R7: After the eighth rising edge the received byte appears at addr 3, status bit 3 is set and `irq` pulses for one cycle in that same cycle.
- R8: With the internal clock, the first falling edge comes within two half periods of setting the run bit. The clock output idles high whenever no transfer is active.
- R9: With control bit 3 set, the external clock input is passed through a two-flop synchronizer. Its edges drive the transfer, and the clock output stays high with its enable low.
- R10: A byte that completes while status bit 3 is set sets status bit 4, leaves addr 3 unchanged and raises no interrupt. While status bit 4 is set no interrupt is raised. Writing status with bit 4 equal to 0 clears it.
- R11: Reading addr 3 clears status bit 3.
- R12: With the run bit kept set, bytes follow back to back and status bit 0 stays high. Clearing the run bit ends the transfer at the next byte boundary, and status bit 0 then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on addr 3 only) |
| addr | input | 2 | Register select |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for the selected register |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Internally generated serial clock |
| sck_oe | output | 1 | Drive enable for the serial clock pin |
| sin | input | 1 | Serial data input |
| sout | output | 1 | Serial data output |
| irq | output | 1 | One-cycle receive interrupt |

## Verification
On every cycle, the assertions tie the interrupt to the receive-full flag and keep it silent while an overrun is flagged. They also check that the receive register holds still when an overrun is raised and that the shift window only opens inside an active transfer. They check that transfers begin only on a falling serial edge, that the output bit moves only on a load or shift, and that the clock idles high. Bit order and data values need the bench's scenarios. So do the position of each flag change within a byte, the back-to-back continuation, the stop at a byte boundary and the recovery of interrupts after the overrun is cleared. The bench sweeps several byte patterns in both bit orders with the internal clock, then runs a continuous, overrun and recovery sequence on the external clock.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

    localparam logic [1:0] MODE_DUPLEX = 2'b10;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_TXB  = 2'd2,
        A_RXB  = 2'd3
    } ssx_addr_e;

    typedef struct packed {
        logic       lsb_first;
        logic       ext_clk;
        logic       start;
        logic [1:0] mode;
    } ssx_ctrl_t;

    typedef enum logic {
        PH_WAIT  = 1'b0,
        PH_SHIFT = 1'b1
    } ssx_phase_e;

endpackage

// File: rtl/ssx_clkgen.sv
module ssx_clkgen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sel,
    input  logic run,
    input  logic sck_in,
    output logic fall_ev,
    output logic rise_ev,
    output logic sck_out
);
    localparam int CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);

    typedef struct packed {
        logic [2:0]    sync;
        logic [CW-1:0] cnt;
        logic          lvl;
    } cg_t;

    cg_t r_q, r_d;
    logic run_int, wrap;

    always_comb begin
        r_d     = r_q;
        r_d.sync = {r_q.sync[1:0], sck_in};
        run_int = run && !ext_sel;
        wrap    = run_int && (r_q.cnt == CW'(HALF_DIV - 1));
        if (!run_int) begin
            r_d.cnt = '0;
            r_d.lvl = 1'b1;
        end else if (wrap) begin
            r_d.cnt = '0;
            r_d.lvl = ~r_q.lvl;
        end else begin
            r_d.cnt = r_q.cnt + CW'(1);
        end
        if (ext_sel) begin
            fall_ev = r_q.sync[2] & ~r_q.sync[1];
            rise_ev = ~r_q.sync[2] & r_q.sync[1];
            sck_out = 1'b1;
        end else begin
            fall_ev = wrap & r_q.lvl;
            rise_ev = wrap & ~r_q.lvl;
            sck_out = r_q.lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.sync <= 3'b111;
            r_q.lvl  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    AST_EXT_CLK_OUT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ext_sel |-> sck_out); // R9

endmodule

// File: rtl/ssx_shifter.sv
module ssx_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic          smp,
    input  logic          lsb_first,
    input  logic [DW-1:0] tx_word,
    input  logic          sin,
    output logic          sout,
    output logic [DW-1:0] rx_next
);
    typedef struct packed {
        logic [DW-1:0] tx;
        logic [DW-1:0] rx;
        logic          so;
    } sh_t;

    sh_t r_q, r_d;
    logic [DW-1:0] src;

    always_comb begin
        r_d = r_q;
        src = load ? tx_word : r_q.tx;
        if (load || adv) begin
            if (lsb_first) begin
                r_d.so = src[0];
                r_d.tx = src >> 1;
            end else begin
                r_d.so = src[DW-1];
                r_d.tx = src << 1;
            end
        end
        if (smp) begin
            if (lsb_first) r_d.rx = {sin, r_q.rx[DW-1:1]};
            else           r_d.rx = {r_q.rx[DW-2:0], sin};
        end
        rx_next = r_d.rx;
        sout    = r_q.so;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.so <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    AST_SOUT_MOVES_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(sout)); // R4

endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
    import ssx_pkg::*;
#(
    parameter int DW       = 8,
    parameter int HALF_DIV = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          sck_in,
    output logic          sck_out,
    output logic          sck_oe,
    input  logic          sin,
    output logic          sout,
    output logic          irq
);
    localparam int CNTW = $clog2(DW);

    typedef struct packed {
        ssx_ctrl_t      ctrl;
        logic [DW-1:0]  txb;
        logic [DW-1:0]  rxb;
        logic           tx_empty;
        logic           rx_full;
        logic           rx_err;
        logic           busy;
        logic           shifting;
        ssx_phase_e     phase;
        logic [CNTW-1:0] fcnt;
        logic [CNTW-1:0] rcnt;
        logic           irq;
    } st_t;

    st_t r_q, r_d;
    logic fall_ev, rise_ev, run, load, adv, smp;
    logic go, in_shift, rx_rd, wr_ctrl, wr_stat, wr_txb;
    logic [DW-1:0] rx_next;

    always_comb begin
        r_d      = r_q;
        r_d.irq  = 1'b0;
        go       = r_q.ctrl.start && (r_q.ctrl.mode == MODE_DUPLEX);
        in_shift = (r_q.phase == PH_SHIFT);
        run      = go || (r_q.busy && in_shift);
        load     = !in_shift && fall_ev && go;
        adv      = in_shift && fall_ev;
        smp      = in_shift && rise_ev;
        rx_rd    = rd_en && (addr == A_RXB);
        wr_ctrl  = wr_en && (addr == A_CTRL);
        wr_stat  = wr_en && (addr == A_STAT);
        wr_txb   = wr_en && (addr == A_TXB);

        if (rx_rd) r_d.rx_full = 1'b0;
        if (!in_shift && r_q.busy && !go) r_d.busy = 1'b0;

        if (load) begin
            r_d.busy     = 1'b1;
            r_d.shifting = 1'b1;
            r_d.phase    = PH_SHIFT;
            r_d.fcnt     = '0;
            r_d.rcnt     = '0;
        end

        if (adv) begin
            r_d.fcnt = r_q.fcnt + CNTW'(1);
            if (r_q.fcnt == CNTW'(DW - 2)) r_d.shifting = 1'b0;
        end

        if (smp) begin
            if (r_q.rcnt == '0) r_d.tx_empty = 1'b1;
            r_d.rcnt = r_q.rcnt + CNTW'(1);
            if (r_q.rcnt == CNTW'(DW - 1)) begin
                r_d.phase = PH_WAIT;
                r_d.rcnt  = '0;
                if (r_q.rx_full && !rx_rd) begin
                    r_d.rx_err = 1'b1;
                end else begin
                    r_d.rxb     = rx_next;
                    r_d.rx_full = 1'b1;
                    r_d.irq     = !r_q.rx_err;
                end
                if (!go) r_d.busy = 1'b0;
            end
        end

        if (wr_ctrl) r_d.ctrl = ssx_ctrl_t'(wdata[4:0]);
        if (wr_stat && !wdata[4]) r_d.rx_err = 1'b0;
        if (wr_txb) begin
            r_d.txb      = wdata;
            r_d.tx_empty = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.tx_empty <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata[4:0] = r_q.ctrl;
            A_STAT:  rdata[4:0] = {r_q.rx_err, r_q.rx_full, r_q.tx_empty,
                                   r_q.shifting, r_q.busy};
            A_TXB:   rdata = r_q.txb;
            default: rdata = r_q.rxb;
        endcase
    end

    ssx_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_sel (r_q.ctrl.ext_clk),
        .run     (run),
        .sck_in  (sck_in),
        .fall_ev (fall_ev),
        .rise_ev (rise_ev),
        .sck_out (sck_out)
    );

    ssx_shifter #(.DW(DW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .adv       (adv),
        .smp       (smp),
        .lsb_first (r_q.ctrl.lsb_first),
        .tx_word   (r_q.txb),
        .sin       (sin),
        .sout      (sout),
        .rx_next   (rx_next)
    );

    assign sck_oe = !r_q.ctrl.ext_clk;
    assign irq    = r_q.irq;

    AST_IRQ_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> r_q.rx_full); // R7
    AST_NO_IRQ_WHILE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.rx_err |-> !irq); // R10
    AST_RXB_KEPT_ON_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.rx_err) |-> $stable(r_q.rxb)); // R10
    AST_SHIFT_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.shifting |-> r_q.busy); // R5
    AST_TXB_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_TXB) |=> !r_q.tx_empty); // R2
    AST_BUSY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.busy) |-> $past(fall_ev)); // R3
    AST_IDLE_CLOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.busy && !r_q.ctrl.ext_clk) |-> sck_out); // R8

endmodule

// File: tb/sim_sync_serial_xcvr.sv
module sim_sync_serial_xcvr;
    localparam int DW = 8;
    localparam int HD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic sck_in = 1'b1, sck_out, sck_oe, sin = 1'b0, sout, irq;

    int checks = 0, errors = 0, irq_cnt = 0, cyc = 0;
    bit done = 0;

    sync_serial_xcvr #(.DW(DW), .HALF_DIV(HD)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sck_in(sck_in), .sck_out(sck_out),
        .sck_oe(sck_oe), .sin(sin), .sout(sout), .irq(irq)
    );

    always #5 clk = ~clk;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (irq) irq_cnt <= irq_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic int_byte(input logic [7:0] v, input logic [7:0] p, input logic lsb);
        logic [7:0] got, st;
        logic [4:0] cw;
        int t0, t1, ic0;
        cw  = {lsb, 1'b0, 1'b1, 2'b10};
        ic0 = irq_cnt;
        got = '0;
        t1  = 0;
        bus_wr(2'd2, v);
        bus_rd(2'd1, st);
        chk("R2 tx empty cleared by write", int'(st[2]), 0);
        bus_wr(2'd0, {3'b0, cw});
        t0 = cyc;
        bus_rd(2'd1, st);
        chk("R3 not active before first fall", int'(st[0]), 0);
        for (int i = 0; i < 8; i++) begin
            @(negedge sck_out);
            if (i == 0) t1 = cyc;
            sin = lsb ? p[i] : p[7-i];
            if (i == 0) bus_wr(2'd0, {3'b0, cw & 5'b11011});
            if (i == 7) begin
                bus_rd(2'd1, st);
                chk("R5 shift flag low after last fall", int'(st[1]), 0);
                chk("R12 active until byte boundary", int'(st[0]), 1);
            end
            @(posedge sck_out);
            #1;
            if (lsb) got[i] = sout; else got[7-i] = sout;
            if (i == 0) begin
                bus_rd(2'd1, st);
                chk("R6 tx empty after first rise", int'(st[2]), 1);
            end
            if (i == 3) begin
                bus_rd(2'd1, st);
                chk("R5 shift flag high mid-byte", int'(st[1]), 1);
            end
        end
        chk("R8 first fall within two half periods",
            int'((t1 - t0) >= 1 && (t1 - t0) <= 2 * HD + 1), 1);
        repeat (3) @(negedge clk);
        chk("R7 one interrupt per byte", irq_cnt - ic0, 1);
        bus_rd(2'd1, st);
        chk("R12 stopped with full and empty set", int'(st[4:0]), 5'h0C);
        repeat (4 * HD) @(negedge clk);
        chk("R8 clock idles high", int'(sck_out), 1);
        chk("R4 transmitted bit stream", int'(got), int'(v));
        bus_rd(2'd3, st);
        chk("R4 received byte", int'(st), int'(p));
        bus_rd(2'd1, st);
        chk("R11 read clears receive full", int'(st[3]), 0);
    endtask

    task automatic ext_byte(input logic [7:0] p, input logic lsb, input int stop_i,
                            input logic [4:0] cw_stop, output logic [7:0] got);
        got = '0;
        for (int i = 0; i < 8; i++) begin
            sck_in = 1'b0;
            sin = lsb ? p[i] : p[7-i];
            if (i == stop_i) bus_wr(2'd0, {3'b0, cw_stop});
            else repeat (2) @(negedge clk);
            repeat (4) @(negedge clk);
            sck_in = 1'b1;
            repeat (6) @(negedge clk);
            if (lsb) got[i] = sout; else got[7-i] = sout;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] st, got;
        int ic;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        bus_rd(2'd1, st);
        chk("R2 reset status only empty set", int'(st[4:0]), 5'h04);
        chk("R8 reset clock high", int'(sck_out), 1);
        chk("R7 reset irq low", int'(irq), 0);

        bus_wr(2'd0, 8'h05);
        repeat (20) @(negedge clk);
        chk("R1 wrong mode keeps clock high", int'(sck_out), 1);
        bus_rd(2'd1, st);
        chk("R1 wrong mode no transfer", int'(st[0]), 0);
        bus_wr(2'd0, 8'h00);

        for (int lsb = 0; lsb < 2; lsb++) begin
            for (int k = 0; k < 6; k++) begin
                int_byte(8'(k * 37 + 5), 8'(~(k * 37 + 5)) ^ 8'(k * 11), lsb[0]);
            end
        end

        sck_in = 1'b1;
        ic = irq_cnt;
        bus_wr(2'd2, 8'hA6);
        bus_wr(2'd0, 8'h0E);
        repeat (5) @(negedge clk);
        bus_rd(2'd1, st);
        chk("R9 no start without external edge", int'(st[0]), 0);
        chk("R9 clock output disabled", int'(sck_oe), 0);
        ext_byte(8'h3C, 1'b0, 99, 5'h0E, got);
        chk("R9 external clock stream", int'(got), 8'hA6);
        bus_rd(2'd1, st);
        chk("R12 continuous stays active", int'(st[4:0]), 5'h0D);
        chk("R7 interrupt on first byte", irq_cnt - ic, 1);
        bus_wr(2'd2, 8'h59);
        bus_rd(2'd1, st);
        chk("R2 refill clears empty", int'(st[2]), 0);
        ext_byte(8'hC1, 1'b0, 3, 5'h0A, got);
        chk("R4 second byte stream", int'(got), 8'h59);
        bus_rd(2'd1, st);
        chk("R10 overrun flagged and stopped", int'(st[4:0]), 5'h1C);
        chk("R10 no interrupt on overrun", irq_cnt - ic, 1);
        bus_rd(2'd3, st);
        chk("R10 receive buffer kept", int'(st), 8'h3C);
        bus_rd(2'd1, st);
        chk("R11 full cleared error kept", int'(st[4:0]), 5'h14);
        bus_wr(2'd1, 8'h00);
        bus_rd(2'd1, st);
        chk("R10 error cleared by write", int'(st[4:0]), 5'h04);

        bus_wr(2'd2, 8'h8D);
        bus_wr(2'd0, 8'h1E);
        ext_byte(8'h72, 1'b1, 2, 5'h1A, got);
        chk("R4 LSB-first external stream", int'(got), 8'h8D);
        chk("R10 interrupts resume after clear", irq_cnt - ic, 2);
        bus_rd(2'd3, st);
        chk("R4 LSB-first received byte", int'(st), 8'h72);
        bus_rd(2'd1, st);
        chk("R12 stopped after byte", int'(st[0]), 0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule